// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks where each of the two ALU operands comes from in the execute stage of a five-stage pipelined processor with 32 architectural registers. A result that has not yet been written back may be needed by the instruction now in execute. The block compares the two source register numbers of that instruction with the destination register numbers of the two older instructions. One older instruction sits in the execute/memory register and the other in the memory/writeback register. When a match is found, the block routes the pending result straight to the ALU input instead of the stale value read from the register file.

The unit has two parts. A control part produces a 2-bit select code for each operand. A datapath part holds the two three-way operand multiplexers that those codes steer. The whole unit is combinational, so the codes and the selected operands follow the inputs in the same cycle. Register 0 always reads as zero, so a write aimed at it is never forwarded. When both older instructions target the wanted register, the younger one's result is used because it is the most recent value.

Top module: `operand_forward`

## Requirements
- R1: When neither older stage qualifies for an operand, its select code is 2'b00 and the ALU operand equals the register-file value carried in the ID/EX register.
- R2: When the EX/MEM write flag is set, the EX/MEM destination is nonzero, and it equals the first source (rs), forwardA is 2'b10 and aluOpA equals exMemResult.
- R3: Under the same EX/MEM conditions checked against the second source (rt), forwardB is 2'b10 and aluOpB equals exMemResult.
- R4: When the MEM/WB write flag is set, the MEM/WB destination is nonzero and equals rs, and the EX/MEM condition for rs does not hold, forwardA is 2'b01 and aluOpA equals memWbResult.
- R5: The same rule as R4 applies to rt, forwardB, and aluOpB.
- R6: When both stages qualify for the same operand, the EX/MEM source wins and the code is 2'b10. This covers a chain of three back-to-back writes to one register.
- R7: A destination of register 0 never causes forwarding from either stage, even when its write flag is set.
- R8: A stage whose write flag is clear never causes forwarding, whatever its destination number.
- R9: The code 2'b11 never appears on either select output. The two operands are decided independently, so rs equal to rt forwards both.
- R10: The select codes and operands settle in the same cycle that the inputs change, with no register stage in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idExRs | input | 5 | First source register number of the instruction in execute |
| idExRt | input | 5 | Second source register number of the instruction in execute |
| exMemRd | input | 5 | Destination register number held in EX/MEM |
| exMemRegWrite | input | 1 | EX/MEM instruction writes the register file |
| memWbRd | input | 5 | Destination register number held in MEM/WB |
| memWbRegWrite | input | 1 | MEM/WB instruction writes the register file |
| idExOpA | input | 32 | Register-file value for the first operand |
| idExOpB | input | 32 | Register-file value for the second operand |
| exMemResult | input | 32 | Result held in EX/MEM |
| memWbResult | input | 32 | Result held in MEM/WB |
| forwardA | output | 2 | Select code for the first operand |
| forwardB | output | 2 | Select code for the second operand |
| aluOpA | output | 32 | Selected first ALU operand |
| aluOpB | output | 32 | Selected second ALU operand |

## Verification
The assertions are evaluated whenever an input changes. They check that no select code is 11, that a zero or non-writing destination never wins, and that the MEM/WB code appears only when EX/MEM does not qualify. They also check that each multiplexer output matches the source its code names. The bench scenarios cover what no single-cycle property can show. One runs a queue-driven instruction stream in which the same register is rewritten three times in a row, checking that the newest result reaches the ALU. Another is a long pseudo-random sweep over a narrow range of register numbers, which makes coincident matches from both stages and on both operands frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_WBSTAGE = 2'b01,
    FWD_MEMSTAGE = 2'b10
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e selA;
    fwdSel_e selB;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] srcRs,
  input  logic [REG_W-1:0] srcRt,
  input  logic [REG_W-1:0] exMemRd,
  input  logic             exMemWe,
  input  logic [REG_W-1:0] memWbRd,
  input  logic             memWbWe,
  output fwdStrobes_t      strobes
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] srcReg;
  logic exMemLive;
  logic memWbLive;

  assign srcReg    = {srcRt, srcRs};
  // A producer stage is eligible only if it writes and its target is not register 0.
  assign exMemLive = exMemWe && (exMemRd != '0);
  assign memWbLive = memWbWe && (memWbRd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : genOp
    logic    hitMem;
    logic    hitWb;
    fwdSel_e opSel;

    always_comb begin
      hitMem = exMemLive && (exMemRd == srcReg[g]);
      hitWb  = memWbLive && (memWbRd == srcReg[g]);
      if (hitMem)     opSel = FWD_MEMSTAGE;
      else if (hitWb) opSel = FWD_WBSTAGE;
      else            opSel = FWD_REGFILE;
    end

    always_comb begin
      if (!$isunknown({srcReg[g], exMemRd, exMemWe, memWbRd, memWbWe})) begin
        a_r9_no_code11: assert (opSel != 2'b11);
        a_r7_zero_never_fwd: assert (!((exMemRd == '0) && (opSel == FWD_MEMSTAGE))
                                     && !((memWbRd == '0) && (opSel == FWD_WBSTAGE)));
        a_r8_write_flag_needed: assert (!(!exMemWe && (opSel == FWD_MEMSTAGE))
                                        && !(!memWbWe && (opSel == FWD_WBSTAGE)));
        a_r6_newest_wins: assert (!((opSel == FWD_WBSTAGE) && exMemWe && (exMemRd != '0)
                                   && (exMemRd == srcReg[g])));
      end
    end
  end

  assign strobes.selA = genOp[0].opSel;
  assign strobes.selB = genOp[1].opSel;

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] exMemVal,
  input  logic [DATA_W-1:0] memWbVal,
  output logic [DATA_W-1:0] aluA,
  output logic [DATA_W-1:0] aluB
);

  localparam int NUM_OP = 2;

  logic [NUM_OP-1:0][DATA_W-1:0] regVal;
  logic [NUM_OP-1:0][DATA_W-1:0] outVal;
  logic [NUM_OP-1:0][1:0]        selCode;

  assign regVal  = {regB, regA};
  assign selCode = {strobes.selB, strobes.selA};

  for (genvar g = 0; g < NUM_OP; g++) begin : genMux
    always_comb begin
      unique case (selCode[g])
        2'b10:   outVal[g] = exMemVal;
        2'b01:   outVal[g] = memWbVal;
        default: outVal[g] = regVal[g]; // 00, and the unused 11, take the register value
      endcase
    end

    always_comb begin
      if (!$isunknown({selCode[g], regVal[g], exMemVal, memWbVal, outVal[g]})) begin
        a_r2_mem_path: assert ((selCode[g] != 2'b10) || (outVal[g] == exMemVal));
        a_r4_wb_path: assert ((selCode[g] != 2'b01) || (outVal[g] == memWbVal));
        a_r1_reg_path: assert ((selCode[g] != 2'b00) || (outVal[g] == regVal[g]));
      end
    end
  end

  assign aluA = outVal[0];
  assign aluB = outVal[1];

endmodule

// File: rtl/operand_forward.sv
module operand_forward
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  idExRs,
  input  logic [REG_W-1:0]  idExRt,
  input  logic [REG_W-1:0]  exMemRd,
  input  logic              exMemRegWrite,
  input  logic [REG_W-1:0]  memWbRd,
  input  logic              memWbRegWrite,
  input  logic [DATA_W-1:0] idExOpA,
  input  logic [DATA_W-1:0] idExOpB,
  input  logic [DATA_W-1:0] exMemResult,
  input  logic [DATA_W-1:0] memWbResult,
  output logic [1:0]        forwardA,
  output logic [1:0]        forwardB,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB
);

  fwdStrobes_t strobes;

  fwd_control #(.REG_W(REG_W)) u_control (
    .srcRs   (idExRs),
    .srcRt   (idExRt),
    .exMemRd (exMemRd),
    .exMemWe (exMemRegWrite),
    .memWbRd (memWbRd),
    .memWbWe (memWbRegWrite),
    .strobes (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_datapath (
    .strobes  (strobes),
    .regA     (idExOpA),
    .regB     (idExOpB),
    .exMemVal (exMemResult),
    .memWbVal (memWbResult),
    .aluA     (aluOpA),
    .aluB     (aluOpB)
  );

  assign forwardA = strobes.selA;
  assign forwardB = strobes.selB;

endmodule

// File: tb/test_operand_forward.sv
module test_operand_forward;

  logic        clk = 1'b0;
  logic [4:0]  idExRs, idExRt, exMemRd, memWbRd;
  logic        exMemRegWrite, memWbRegWrite;
  logic [31:0] idExOpA, idExOpB, exMemResult, memWbResult;
  logic [1:0]  forwardA, forwardB;
  logic [31:0] aluOpA, aluOpB;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int          rd;
    bit          we;
    logic [31:0] val;
  } instr_t;

  instr_t pipeQ[$];

  always #10 clk = ~clk; // 50 MHz

  operand_forward i_operand_forward (
    .idExRs(idExRs), .idExRt(idExRt), .exMemRd(exMemRd), .exMemRegWrite(exMemRegWrite),
    .memWbRd(memWbRd), .memWbRegWrite(memWbRegWrite), .idExOpA(idExOpA), .idExOpB(idExOpB),
    .exMemResult(exMemResult), .memWbResult(memWbResult), .forwardA(forwardA),
    .forwardB(forwardB), .aluOpA(aluOpA), .aluOpB(aluOpB)
  );

  // Behavioural reference: 2 = EX/MEM, 1 = MEM/WB, 0 = register file.
  function automatic int refSel(int src, int emRd, bit emWe, int mwRd, bit mwWe);
    if (emWe && emRd != 0 && emRd == src) return 2;
    if (mwWe && mwRd != 0 && mwRd == src) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] refVal(int s, logic [31:0] r);
    if (s == 2) return exMemResult;
    if (s == 1) return memWbResult;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int rs, int rt, int emRd, bit emWe, int mwRd, bit mwWe,
                       logic [31:0] a, logic [31:0] b, logic [31:0] em, logic [31:0] mw);
    @(posedge clk);
    #2;
    idExRs = rs[4:0]; idExRt = rt[4:0]; exMemRd = emRd[4:0]; exMemRegWrite = emWe;
    memWbRd = mwRd[4:0]; memWbRegWrite = mwWe;
    idExOpA = a; idExOpB = b; exMemResult = em; memWbResult = mw;
  endtask

  task automatic compare(string tag);
    int sa, sb;
    @(negedge clk);
    sa = refSel(int'(idExRs), int'(exMemRd), exMemRegWrite, int'(memWbRd), memWbRegWrite);
    sb = refSel(int'(idExRt), int'(exMemRd), exMemRegWrite, int'(memWbRd), memWbRegWrite);
    check({tag, " forwardA"}, 32'(forwardA), 32'(sa));
    check({tag, " forwardB"}, 32'(forwardB), 32'(sb));
    check({tag, " aluOpA"}, aluOpA, refVal(sa, idExOpA));
    check({tag, " aluOpB"}, aluOpB, refVal(sb, idExOpB));
    check({tag, " R9 no code 11"}, 32'(forwardA == 2'b11 || forwardB == 2'b11), 0);
  endtask

  task automatic step(string tag, int rs, int rt, int emRd, bit emWe, int mwRd, bit mwWe,
                      int expA, int expB);
    drive(rs, rt, emRd, emWe, mwRd, mwWe, 32'hA0A0_0001, 32'hB0B0_0002,
          32'hE3E3_0003, 32'hC4C4_0004);
    compare(tag);
    check({tag, " directed A"}, 32'(forwardA), 32'(expA));
    check({tag, " directed B"}, 32'(forwardB), 32'(expB));
  endtask

  // Feeds an instruction stream; the instruction in EX reads rs/rt while older ones
  // occupy EX/MEM (pipeQ[0]) and MEM/WB (pipeQ[1]).
  task automatic issue(string tag, int rd, int rs, int rt, logic [31:0] res, int expA, int expB);
    instr_t em, mw, cur;
    em = (pipeQ.size() > 0) ? pipeQ[0] : '{0, 1'b0, 32'h0};
    mw = (pipeQ.size() > 1) ? pipeQ[1] : '{0, 1'b0, 32'h0};
    drive(rs, rt, em.rd, em.we, mw.rd, mw.we, 32'h1111_0000, 32'h2222_0000, em.val, mw.val);
    compare(tag);
    check({tag, " chain A"}, 32'(forwardA), 32'(expA));
    check({tag, " chain B"}, 32'(forwardB), 32'(expB));
    cur = '{rd, 1'b1, res};
    pipeQ.push_front(cur);
    if (pipeQ.size() > 2) void'(pipeQ.pop_back());
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idExRs = '0; idExRt = '0; exMemRd = '0; memWbRd = '0;
    exMemRegWrite = 0; memWbRegWrite = 0;
    idExOpA = '0; idExOpB = '0; exMemResult = '0; memWbResult = '0;

    // Initial quiet state: nothing written, codes 00 (R1)
    step("R1 idle", 3, 4, 0, 0, 0, 0, 0, 0);
    step("R1 no match", 3, 4, 5, 1, 6, 1, 0, 0);
    step("R2 exmem rs", 7, 4, 7, 1, 0, 0, 2, 0);
    step("R3 exmem rt", 3, 9, 9, 1, 0, 0, 0, 2);
    step("R4 memwb rs", 12, 4, 5, 1, 12, 1, 1, 0);
    step("R5 memwb rt", 3, 13, 0, 0, 13, 1, 0, 1);
    step("R6 both stages rs", 8, 2, 8, 1, 8, 1, 2, 0);
    step("R6 both stages rt", 2, 8, 8, 1, 8, 1, 0, 2);
    step("R7 zero exmem", 0, 0, 0, 1, 0, 0, 0, 0);
    step("R7 zero both", 0, 0, 0, 1, 0, 1, 0, 0);
    step("R8 exmem off", 6, 6, 6, 0, 0, 0, 0, 0);
    step("R8 exmem off memwb on", 6, 6, 6, 0, 6, 1, 1, 1);
    step("R8 both off", 6, 6, 6, 0, 6, 0, 0, 0);
    step("R9 rs eq rt", 10, 10, 10, 1, 0, 0, 2, 2);
    step("R9 split stages", 10, 11, 10, 1, 11, 1, 2, 1);
    step("R10 immediate change", 31, 31, 31, 1, 31, 1, 2, 2);

    // Chain: three successive writes to register 1 (R6)
    pipeQ.delete();
    issue("R6 chain i1", 1, 1, 2, 32'h0000_0010, 0, 0);
    issue("R6 chain i2", 1, 1, 3, 32'h0000_0020, 2, 0);
    issue("R6 chain i3", 1, 1, 4, 32'h0000_0030, 2, 0);
    issue("R6 chain reader", 5, 1, 1, 32'h0000_0040, 2, 2);
    check("R6 chain newest value", aluOpA, 32'h0000_0030);

    // Pseudo-random sweep with narrow register numbers (R1..R9)
    for (int i = 0; i < 400; i++) begin
      drive(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            $urandom, $urandom, $urandom, $urandom);
      compare("R1-sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule